// File: doc/BRIEF.md
# Posted Write Command Selector

This block sits between a queue of downstream memory write requests and the engine that drives the PCI-X bus. Each request carries a byte address, a length in dwords, first and last byte enables, and the relaxed-ordering and no-snoop attributes. The block holds one request at a time and picks the PCI-X write command for it. The choice is a plain memory write, or a memory write block when the write covers whole cache lines with every byte enabled and does not ask for no-snoop. The cache-line size is a programmable input.

After the selector hands a command segment to the bus engine, the engine reports how many dwords the target accepted. If the target disconnected early, the selector works out the leftover segment and sends it out again with a freshly chosen command. A write that was aligned at first can be left unaligned once part of it has gone through. A retry, where zero dwords were accepted, repeats the same segment. The block takes in no new request until the whole write has been accepted. Writes therefore leave in arrival order, whatever the relaxed-ordering bit says.

Top module: `pwcs_cmd_select`

## Requirements
- R1: While reset is high and in the cycle after it falls, `cmd_valid` is 0 and `req_ready` is 1.
- R2: A segment is issued as memory write block (`cmd_kind`=1) when all of these hold: `cls_dw` is a nonzero power of two; the address has bits [1:0] zero and its dword index is a multiple of `cls_dw`; the length is a nonzero multiple of `cls_dw`; `first_be` is 4'hF; `last_be` is 4'hF when the length is above 1; and the no-snoop bit is 0.
- R3: A segment with the no-snoop bit set is issued as plain memory write (`cmd_kind`=0).
- R4: A segment with a misaligned start, a length that is not a whole number of lines, or any byte enable cleared is issued as plain memory write.
- R5: A zero-length write, or a single-dword write with a partial first byte enable, is issued as plain memory write. A zero-length segment is finished by a report of 0 accepted dwords.
- R6: `cmd_ro` and `cmd_ns` equal the request's attributes. The first command of a request carries its address, length and byte enables unchanged, one cycle after the request is accepted.
- R7: A report of `rsp_acc_dw` = n, with 0 < n < length, causes the next command to carry address + 4n and length - n. Its first_be is 4'hF and its last_be is the original one. If the new length is 1, first_be takes the original last_be and last_be becomes 0. The command kind is chosen again for this segment.
- R8: A report of 0 accepted dwords on a nonzero segment sends the same segment again with the same address, length, enables and kind.
- R9: From the acceptance of a request until a report with `rsp_acc_dw` at least the remaining length, `req_ready` is 0. `req_ready` and `cmd_valid` are never high together. The relaxed-ordering bit has no effect on this.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and every command field stays stable.
- R11: A `cls_dw` of zero or of a value that is not a power of two makes every segment a plain memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_dw | input | 8 | Cache-line size in dwords |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Selector can take a request |
| req_addr | input | 32 | Request byte address |
| req_len | input | 11 | Request length in dwords |
| req_first_be | input | 4 | First-dword byte enables |
| req_last_be | input | 4 | Last-dword byte enables |
| req_ro | input | 1 | Relaxed-ordering attribute |
| req_ns | input | 1 | No-snoop attribute |
| cmd_valid | output | 1 | Command segment offered to the bus engine |
| cmd_ready | input | 1 | Bus engine takes the command |
| cmd_kind | output | 1 | 0 plain memory write, 1 memory write block |
| cmd_addr | output | 32 | Segment byte address |
| cmd_len | output | 11 | Segment length in dwords |
| cmd_first_be | output | 4 | Segment first-dword byte enables |
| cmd_last_be | output | 4 | Segment last-dword byte enables |
| cmd_ro | output | 1 | Relaxed-ordering attribute, passed through |
| cmd_ns | output | 1 | No-snoop attribute, passed through |
| rsp_valid | input | 1 | Outcome of the issued segment |
| rsp_acc_dw | input | 11 | Dwords the target accepted |

## Verification
On every cycle the assertions check several properties. A block command never carries no-snoop, a zero length or a partial first enable. The request and command handshakes are never open together. A stalled command holds still. A disconnect moves the address by four bytes per accepted dword, and a retry repeats the segment. Attribute pass-through and the post-reset idle state are checked too. The exact command choice depends on line size, alignment, length and every byte enable, and only the bench's vector table can show it. The same holds for the full chain of remainders that turns a block write into plain writes, and for the single-dword tail that takes the last byte enables.

// File: rtl/pwcs_pkg.sv
package pwcs_pkg;

    parameter int unsigned PW_ADDR_W = 32;
    parameter int unsigned PW_LEN_W  = 11;
    parameter int unsigned PW_BE_W   = 4;
    parameter int unsigned PW_CLS_W  = 8;

    localparam logic [PW_BE_W-1:0] BE_ALL = {PW_BE_W{1'b1}};

    typedef enum logic {
        CMD_MW  = 1'b0,
        CMD_MWB = 1'b1
    } wr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } sel_state_e;

    typedef struct packed {
        logic [PW_ADDR_W-1:0] addr;
        logic [PW_LEN_W-1:0]  len;
        logic [PW_BE_W-1:0]   first_be;
        logic [PW_BE_W-1:0]   last_be;
        logic                 ro;
        logic                 ns;
    } wr_seg_t;

    function automatic logic is_pow2(input logic [PW_CLS_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [PW_ADDR_W-1:0] dw_to_bytes(input logic [PW_LEN_W-1:0] dw);
        return PW_ADDR_W'({dw, 2'b00});
    endfunction

endpackage

// File: rtl/pwcs_line_check.sv
module pwcs_line_check
    import pwcs_pkg::*;
#(
    parameter int unsigned LEN_W = PW_LEN_W,
    parameter int unsigned CLS_W = PW_CLS_W
) (
    input  wr_seg_t           seg,
    input  logic [CLS_W-1:0]  cls_dw,
    output wr_cmd_e           kind
);
    localparam int unsigned IDX_HI = LEN_W + 1;

    logic [LEN_W-1:0] line_mask;
    logic [LEN_W-1:0] dw_idx;
    logic             cls_ok;
    logic             start_ok;
    logic             span_ok;
    logic             be_ok;

    always_comb begin
        cls_ok    = is_pow2(cls_dw);
        line_mask = LEN_W'(cls_dw) - 1'b1;
        dw_idx    = seg.addr[IDX_HI:2];
        start_ok  = (seg.addr[1:0] == 2'b00) && ((dw_idx & line_mask) == '0);
        span_ok   = (seg.len != '0) && ((seg.len & line_mask) == '0);
        be_ok     = (seg.first_be == BE_ALL) &&
                    ((seg.len == LEN_W'(1)) || (seg.last_be == BE_ALL));
        kind      = (cls_ok && start_ok && span_ok && be_ok && !seg.ns) ? CMD_MWB : CMD_MW;
    end

endmodule

// File: rtl/pwcs_remainder.sv
module pwcs_remainder
    import pwcs_pkg::*;
#(
    parameter int unsigned LEN_W = PW_LEN_W
) (
    input  wr_seg_t          seg,
    input  logic [LEN_W-1:0] acc_dw,
    output wr_seg_t          next_seg,
    output logic             all_done
);
    logic [LEN_W-1:0] left_dw;

    always_comb begin
        all_done = (acc_dw >= seg.len);
        left_dw  = seg.len - acc_dw;
        next_seg = seg;
        if (!all_done && (acc_dw != '0)) begin
            next_seg.addr = seg.addr + dw_to_bytes(acc_dw);
            next_seg.len  = left_dw;
            if (left_dw == LEN_W'(1)) begin
                next_seg.first_be = seg.last_be;
                next_seg.last_be  = '0;
            end else begin
                next_seg.first_be = BE_ALL;
                next_seg.last_be  = seg.last_be;
            end
        end
    end

endmodule

// File: rtl/pwcs_seq_fsm.sv
module pwcs_seq_fsm
    import pwcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       cmd_ready,
    input  logic       rsp_valid,
    input  logic       rem_done,
    output logic       req_ready,
    output logic       cmd_valid,
    output logic       load_req,
    output logic       load_rem
);
    sel_state_e state_q;
    sel_state_e state_d;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_ISSUE);
        load_req  = req_ready && req_valid;
        load_rem  = (state_q == ST_WAIT) && rsp_valid && !rem_done;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = rem_done ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pwcs_cmd_select.sv
module pwcs_cmd_select
    import pwcs_pkg::*;
#(
    parameter int unsigned ADDR_W = PW_ADDR_W,
    parameter int unsigned LEN_W  = PW_LEN_W,
    parameter int unsigned BE_W   = PW_BE_W,
    parameter int unsigned CLS_W  = PW_CLS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CLS_W-1:0]  cls_dw,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [BE_W-1:0]   req_first_be,
    input  logic [BE_W-1:0]   req_last_be,
    input  logic              req_ro,
    input  logic              req_ns,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [BE_W-1:0]   cmd_first_be,
    output logic [BE_W-1:0]   cmd_last_be,
    output logic              cmd_ro,
    output logic              cmd_ns,
    input  logic              rsp_valid,
    input  logic [LEN_W-1:0]  rsp_acc_dw
);
    wr_seg_t seg_q;
    wr_seg_t req_seg;
    wr_seg_t rem_seg;
    wr_seg_t load_seg;
    wr_cmd_e kind_q;
    wr_cmd_e load_kind;
    logic    rem_done;
    logic    load_req;
    logic    load_rem;

    always_comb begin
        req_seg.addr     = req_addr;
        req_seg.len      = req_len;
        req_seg.first_be = req_first_be;
        req_seg.last_be  = req_last_be;
        req_seg.ro       = req_ro;
        req_seg.ns       = req_ns;
        load_seg         = load_req ? req_seg : rem_seg;
    end

    pwcs_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rem_done  (rem_done),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .load_req  (load_req),
        .load_rem  (load_rem)
    );

    pwcs_remainder #(.LEN_W(LEN_W)) u_rem (
        .seg      (seg_q),
        .acc_dw   (rsp_acc_dw),
        .next_seg (rem_seg),
        .all_done (rem_done)
    );

    pwcs_line_check #(.LEN_W(LEN_W), .CLS_W(CLS_W)) u_line (
        .seg    (load_seg),
        .cls_dw (cls_dw),
        .kind   (load_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= '0;
            kind_q <= CMD_MW;
        end else if (load_req || load_rem) begin
            seg_q  <= load_seg;
            kind_q <= load_kind;
        end
    end

    always_comb begin
        cmd_kind     = kind_q;
        cmd_addr     = seg_q.addr;
        cmd_len      = seg_q.len;
        cmd_first_be = seg_q.first_be;
        cmd_last_be  = seg_q.last_be;
        cmd_ro       = seg_q.ro;
        cmd_ns       = seg_q.ns;
    end

endmodule

// File: rtl/pwcs_cmd_select_chk.sv
module pwcs_cmd_select_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_ro,
    input logic        req_ns,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        cmd_kind,
    input logic [31:0] cmd_addr,
    input logic [10:0] cmd_len,
    input logic [3:0]  cmd_first_be,
    input logic [3:0]  cmd_last_be,
    input logic        cmd_ro,
    input logic        cmd_ns,
    input logic        rsp_valid,
    input logic [10:0] rsp_acc_dw
);
    logic waiting;
    assign waiting = !cmd_valid && !req_ready;

    // R1
    reset_idle_chk: assert property (@(posedge clk) $fell(rst) |-> (!cmd_valid && req_ready));

    // R3
    block_no_snoop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind) |-> !cmd_ns);

    // R5
    block_full_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind) |-> ((cmd_len != 11'd0) && (cmd_first_be == 4'hF)));

    // R6
    attr_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_valid && cmd_ro == $past(req_ro) && cmd_ns == $past(req_ns)));

    // R7
    remainder_step_chk: assert property (@(posedge clk) disable iff (rst)
        (waiting && rsp_valid && rsp_acc_dw != 11'd0 && rsp_acc_dw < cmd_len) |=>
        (cmd_valid && cmd_addr == $past(cmd_addr) + {19'd0, $past(rsp_acc_dw), 2'b00}
                   && cmd_len == $past(cmd_len) - $past(rsp_acc_dw)));

    // R8
    retry_same_chk: assert property (@(posedge clk) disable iff (rst)
        (waiting && rsp_valid && rsp_acc_dw == 11'd0 && cmd_len != 11'd0) |=>
        (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_kind)
                   && $stable(cmd_first_be) && $stable(cmd_last_be)));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && cmd_valid));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
        (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_len)
                   && $stable(cmd_first_be) && $stable(cmd_last_be)
                   && $stable(cmd_ro) && $stable(cmd_ns)));

endmodule

bind pwcs_cmd_select pwcs_cmd_select_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_ro       (req_ro),
    .req_ns       (req_ns),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_kind     (cmd_kind),
    .cmd_addr     (cmd_addr),
    .cmd_len      (cmd_len),
    .cmd_first_be (cmd_first_be),
    .cmd_last_be  (cmd_last_be),
    .cmd_ro       (cmd_ro),
    .cmd_ns       (cmd_ns),
    .rsp_valid    (rsp_valid),
    .rsp_acc_dw   (rsp_acc_dw)
);

// File: tb/pwcs_cmd_select_tb_top.sv
module pwcs_cmd_select_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cls_dw = 8'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [10:0] req_len = '0;
    logic [3:0]  req_first_be = '0;
    logic [3:0]  req_last_be = '0;
    logic        req_ro = 1'b0;
    logic        req_ns = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_kind;
    logic [31:0] cmd_addr;
    logic [10:0] cmd_len;
    logic [3:0]  cmd_first_be;
    logic [3:0]  cmd_last_be;
    logic        cmd_ro;
    logic        cmd_ns;
    logic        rsp_valid = 1'b0;
    logic [10:0] rsp_acc_dw = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwcs_cmd_select dut_i (
        .clk(clk), .rst(rst), .cls_dw(cls_dw),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_first_be(req_first_be), .req_last_be(req_last_be),
        .req_ro(req_ro), .req_ns(req_ns),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_first_be(cmd_first_be),
        .cmd_last_be(cmd_last_be), .cmd_ro(cmd_ro), .cmd_ns(cmd_ns),
        .rsp_valid(rsp_valid), .rsp_acc_dw(rsp_acc_dw)
    );

    typedef struct packed {
        logic [7:0]  cls;
        logic [31:0] addr;
        logic [10:0] len;
        logic [3:0]  fbe;
        logic [3:0]  lbe;
        logic        ro;
        logic        ns;
        logic        kind;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{8'd16, 32'h0000_1000, 11'd16, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1}, // R2 aligned whole line
        '{8'd16, 32'h0000_1000, 11'd16, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0}, // R3 no-snoop
        '{8'd16, 32'h0000_1020, 11'd16, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R4 misaligned
        '{8'd16, 32'h0000_1000, 11'd20, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R4 partial line
        '{8'd16, 32'h0000_1000, 11'd16, 4'hE, 4'hF, 1'b0, 1'b0, 1'b0}, // R4 first be
        '{8'd16, 32'h0000_1000, 11'd16, 4'hF, 4'h7, 1'b0, 1'b0, 1'b0}, // R4 last be
        '{8'd16, 32'h0000_1000, 11'd0,  4'h0, 4'h0, 1'b0, 1'b0, 1'b0}, // R5 zero length
        '{8'd1,  32'h0000_2004, 11'd1,  4'h3, 4'h0, 1'b0, 1'b0, 1'b0}, // R5 single partial
        '{8'd1,  32'h0000_2004, 11'd1,  4'hF, 4'h0, 1'b0, 1'b0, 1'b1}, // R2 single full, line 1
        '{8'd12, 32'h0000_0000, 11'd24, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R11 non power of two
        '{8'd0,  32'h0000_0000, 11'd16, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R11 zero size
        '{8'd32, 32'h0000_0080, 11'd64, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1}, // R6 ro passes, R9
        '{8'd8,  32'h0000_0040, 11'd32, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0}  // R6 both attributes
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_req(input logic [31:0] a, input logic [10:0] l, input logic [3:0] f,
                            input logic [3:0] b, input logic ro, input logic ns);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        req_first_be = f; req_last_be = b; req_ro = ro; req_ns = ns;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take_cmd();
        while (!cmd_valid) @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic respond(input logic [10:0] acc);
        rsp_valid = 1'b1; rsp_acc_dw = acc;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic expect_cmd(input string req, input logic k, input logic [31:0] a,
                              input logic [10:0] l, input logic [3:0] f, input logic [3:0] b);
        check(cmd_valid == 1'b1, req, {63'd0, cmd_valid}, 64'd1);
        check(cmd_kind == k, req, {63'd0, cmd_kind}, {63'd0, k});
        check(cmd_addr == a, req, {32'd0, cmd_addr}, {32'd0, a});
        check(cmd_len == l, req, {53'd0, cmd_len}, {53'd0, l});
        check({cmd_first_be, cmd_last_be} == {f, b}, req,
              {56'd0, cmd_first_be, cmd_last_be}, {56'd0, f, b});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check(!cmd_valid && req_ready, "R1", {62'd0, cmd_valid, req_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        // R1 after reset
        check(!cmd_valid && req_ready, "R1", {62'd0, cmd_valid, req_ready}, 64'd1);

        for (int i = 0; i < NVEC; i++) begin
            cls_dw = VEC[i].cls;
            send_req(VEC[i].addr, VEC[i].len, VEC[i].fbe, VEC[i].lbe, VEC[i].ro, VEC[i].ns);
            // first command one cycle after acceptance: R2 R3 R4 R5 R6 R11
            expect_cmd($sformatf("R2/R4 vector %0d", i), VEC[i].kind, VEC[i].addr,
                       VEC[i].len, VEC[i].fbe, VEC[i].lbe);
            check({cmd_ro, cmd_ns} == {VEC[i].ro, VEC[i].ns}, "R6",
                  {62'd0, cmd_ro, cmd_ns}, {62'd0, VEC[i].ro, VEC[i].ns});
            take_cmd();
            respond(VEC[i].len);
            check(req_ready == 1'b1, "R5 R9 done", {63'd0, req_ready}, 64'd1);
        end

        // Disconnect chain, block write turning into plain write: R7 R8 R9
        cls_dw = 8'd16;
        send_req(32'h0000_1000, 11'd48, 4'hF, 4'hF, 1'b1, 1'b0);
        expect_cmd("R2 chain start", 1'b1, 32'h0000_1000, 11'd48, 4'hF, 4'hF);
        take_cmd();
        check(req_ready == 1'b0, "R9", {63'd0, req_ready}, 64'd0);
        respond(11'd16);
        expect_cmd("R7 line remainder", 1'b1, 32'h0000_1040, 11'd32, 4'hF, 4'hF);
        check(req_ready == 1'b0, "R9", {63'd0, req_ready}, 64'd0);
        take_cmd();
        respond(11'd5);
        expect_cmd("R7 broken remainder", 1'b0, 32'h0000_1054, 11'd27, 4'hF, 4'hF);
        take_cmd();
        respond(11'd0);
        expect_cmd("R8 retry", 1'b0, 32'h0000_1054, 11'd27, 4'hF, 4'hF);
        check(req_ready == 1'b0, "R9", {63'd0, req_ready}, 64'd0);
        take_cmd();
        respond(11'd30);
        check(req_ready == 1'b1 && !cmd_valid, "R9 release", {62'd0, req_ready, cmd_valid}, 64'd2);

        // Tail of one dword takes the last enables: R7
        send_req(32'h0000_3000, 11'd4, 4'hF, 4'h3, 1'b0, 1'b0);
        expect_cmd("R4 tail start", 1'b0, 32'h0000_3000, 11'd4, 4'hF, 4'h3);
        take_cmd();
        respond(11'd3);
        expect_cmd("R7 single tail", 1'b0, 32'h0000_300C, 11'd1, 4'h3, 4'h0);
        take_cmd();
        respond(11'd1);

        // Stall holds the command: R10
        send_req(32'h0000_4000, 11'd16, 4'hF, 4'hF, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        expect_cmd("R10 stall", 1'b1, 32'h0000_4000, 11'd16, 4'hF, 4'hF);
        take_cmd();
        respond(11'd16);

        // Request offered while busy waits: R9
        send_req(32'h0000_5000, 11'd16, 4'hF, 4'hF, 1'b1, 1'b0);
        req_valid = 1'b1; req_addr = 32'h0000_6000; req_len = 11'd2;
        req_first_be = 4'hF; req_last_be = 4'hF; req_ro = 1'b1; req_ns = 1'b0;
        @(negedge clk);
        expect_cmd("R9 first kept", 1'b1, 32'h0000_5000, 11'd16, 4'hF, 4'hF);
        take_cmd();
        req_valid = 1'b0;
        respond(11'd16);
        check(req_ready == 1'b1, "R9", {63'd0, req_ready}, 64'd1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule